// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel that sits next to a free-running timer counter. It picks one of three inputs: the channel's own pin, the pin of the neighbouring channel, or an internal trigger line. The picked signal is resynchronised to the timer clock and cleaned by a programmable sampling filter. An edge detector then turns the filtered level into events of the chosen polarity, and an event divider keeps only every 1st, 2nd, 4th or 8th of them.

Each event that survives latches the counter value, first into an internal shadow stage and one clock later into the register that software reads. In the same clock a sticky status flag is set. An interrupt request is raised while the flag is set and the interrupt is enabled. A capture that lands while the flag is still set marks an overcapture, and the newer value replaces the older one. Software uses the block to time pulse widths and periods, for example by capturing on both edges and subtracting successive values.

Top module: `icap_channel`

## Requirements
- R1: `src_sel_i` picks the input: 2'b01 own pin, 2'b10 neighbour pin, 2'b11 internal trigger. 2'b00 puts the channel in output use: no capture happens and the event divider is held at zero.
- R2: The input passes through two synchroniser flops. If a new level is first sampled at clock edge k (filter setting 0, divide by 1, matching edge), the counter value present just before edge k+3 is captured, and `cap_val_o` and `cap_flag_o` change at edge k+4.
- R3: `edge_sel_i` picks the capture edge: 2'b00 falling, 2'b01 rising, 2'b10 or 2'b11 both edges.
- R4: `psc_sel_i` sets how many qualifying edges make one capture: 2'b00 every edge, 2'b01 every 2nd, 2'b10 every 4th, 2'b11 every 8th. The edge count restarts from zero while capture is disabled, while the source is 2'b00, and in any cycle where the code differs from its value one clock earlier.
- R5: `flt_cfg_i[3:2]` = r samples the synchronised input on clocks where a 3-bit counter, cleared by reset and advanced every clock, is a multiple of 2^r. `flt_cfg_i[1:0]` = n requires 2^n consecutive samples that differ from the accepted level before the new level is accepted. A sample equal to the accepted level restarts the run.
- R6: The counter value is held in a shadow stage and copied to `cap_val_o` one clock later. `cap_val_o` changes at no other time.
- R7: Every copy into `cap_val_o` sets `cap_flag_o` in the same clock. A high `flag_clr_i` clears it. When a set and a clear meet in one clock, the set wins, and the flag otherwise holds.
- R8: `irq_o` is high exactly while `cap_flag_o` and `irq_en_i` are both high.
- R9: A copy into `cap_val_o` while `cap_flag_o` is set and not being cleared sets `ovr_flag_o`. `ovr_clr_i` clears it, and a set in the same clock wins.
- R10: With `cap_en_i` low, no edge produces a capture.
- R11: After reset, `cap_val_o` is zero and `cap_flag_o`, `ovr_flag_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Counter value to capture |
| pin_own_i | input | 1 | This channel's pin |
| pin_nbr_i | input | 1 | Neighbouring channel's pin |
| trig_i | input | 1 | Internal trigger line |
| src_sel_i | input | 2 | Source select (R1 codes) |
| edge_sel_i | input | 2 | Capture edge select (R3 codes) |
| psc_sel_i | input | 2 | Event divider code (R4) |
| flt_cfg_i | input | 4 | Filter rate and run length (R5) |
| cap_en_i | input | 1 | Capture enable |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clear capture flag |
| ovr_clr_i | input | 1 | Clear overcapture flag |
| cap_val_o | output | CNT_W | Captured counter value |
| cap_flag_o | output | 1 | Capture flag |
| ovr_flag_o | output | 1 | Overcapture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the exact capture latency. A design that drops or adds a pipeline stage would latch a counter value off by one and show the flag a cycle early or late. It checks short pulses against the filter run length and sample rate: a filter that counts non-consecutive samples, or that samples every clock, would let a glitch through. It checks that the divider restarts when its code changes and when capture is turned off; a divider that kept its old count would capture on the wrong edge. It also checks a clear that arrives together with a new capture, where a design that gave the clear priority would lose a capture and miss the overcapture.

// File: rtl/icap_pkg.sv
package icap_pkg;
   localparam logic [1:0] SRC_OUT = 2'b00;
   localparam logic [1:0] SRC_OWN = 2'b01;
   localparam logic [1:0] SRC_NBR = 2'b10;
   localparam logic [1:0] SRC_TRG = 2'b11;

   localparam int FLT_CFG_W = 4;
   localparam int PSC_CNT_W = 3;
   localparam int RUN_W     = 4;

   typedef enum logic [1:0] {
      EDGE_FALL = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_ANY2 = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_e;

   // last count value before a capture fires: 0, 1, 3, 7
   function automatic logic [PSC_CNT_W-1:0] psc_last(input logic [1:0] code);
      case (code)
         2'b00:   psc_last = 3'd0;
         2'b01:   psc_last = 3'd1;
         2'b10:   psc_last = 3'd3;
         default: psc_last = 3'd7;
      endcase
   endfunction

   function automatic logic [2:0] tick_mask(input logic [1:0] rate);
      case (rate)
         2'b00:   tick_mask = 3'd0;
         2'b01:   tick_mask = 3'd1;
         2'b10:   tick_mask = 3'd3;
         default: tick_mask = 3'd7;
      endcase
   endfunction

   function automatic logic [RUN_W-1:0] run_need(input logic [1:0] n);
      case (n)
         2'b00:   run_need = 4'd1;
         2'b01:   run_need = 4'd2;
         2'b10:   run_need = 4'd4;
         default: run_need = 4'd8;
      endcase
   endfunction
endpackage

// File: rtl/icap_infilter.sv
module icap_infilter
   import icap_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 raw_i,
   input  logic [FLT_CFG_W-1:0] flt_cfg_i,
   output logic                 level_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("icap_infilter: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sy;
   logic                   smp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '0;
      else        sy <= {sy[SYNC_STAGES-2:0], raw_i};
   end
   assign smp = sy[LAST];

   if (FILTER_EN) begin : g_filter
      logic [2:0]       tk;
      logic [RUN_W-1:0] run;
      logic [RUN_W-1:0] need;
      logic             tick;
      logic             lvl;

      assign tick = ((tk & tick_mask(flt_cfg_i[3:2])) == 3'd0);
      assign need = run_need(flt_cfg_i[1:0]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tk  <= 3'd0;
            run <= '0;
            lvl <= 1'b0;
         end else begin
            tk <= tk + 3'd1;
            if (tick) begin
               if (smp == lvl) begin
                  run <= '0;
               end else if (run + 4'd1 >= need) begin
                  lvl <= smp;
                  run <= '0;
               end else begin
                  run <= run + 4'd1;
               end
            end
         end
      end
      assign level_o = lvl;

      // R5: accepted level moves only on a sample tick
      assert_filt_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(lvl) |-> $past(tick));
      // R5: the run of differing samples never reaches the largest run length
      assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
         run < 4'd8);
   end else begin : g_bypass
      logic lvl;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl <= 1'b0;
         else        lvl <= smp;
      end
      assign level_o = lvl;
   end
endmodule

// File: rtl/icap_evpsc.sv
module icap_evpsc
   import icap_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       level_i,
   input  logic [1:0] edge_sel_i,
   input  logic [1:0] psc_sel_i,
   input  logic       arm_i,
   output logic       fire_o
);
   logic                 prev;
   logic                 rise;
   logic                 fall;
   logic                 hit;
   logic [1:0]           psc_q;
   logic                 restart;
   logic [PSC_CNT_W-1:0] pc;
   logic [PSC_CNT_W-1:0] last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= 1'b0;
         psc_q <= 2'b00;
      end else begin
         prev  <= level_i;
         psc_q <= psc_sel_i;
      end
   end

   assign rise = level_i & ~prev;
   assign fall = ~level_i & prev;

   always_comb begin
      case (edge_e'(edge_sel_i))
         EDGE_FALL: hit = fall;
         EDGE_RISE: hit = rise;
         default:   hit = rise | fall;
      endcase
   end

   assign restart = !arm_i || (psc_sel_i != psc_q);
   assign last    = psc_last(psc_sel_i);
   assign fire_o  = hit && !restart && (pc == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc <= '0;
      else if (restart) pc <= '0;
      else if (hit)     pc <= (pc == last) ? '0 : pc + 3'd1;
   end

   // R4: the edge count stays below the selected division while counting
   assert_psc_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (pc <= last));
   // R4: a restart always leaves the count at zero
   assert_psc_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pc == '0));
endmodule

// File: rtl/icap_latch.sv
module icap_latch #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             fire_i,
   input  logic             flag_clr_i,
   input  logic             ovr_clr_i,
   output logic [CNT_W-1:0] cap_val_o,
   output logic             flag_o,
   output logic             ovr_o
);
   logic [CNT_W-1:0] shadow;
   logic             pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow    <= '0;
         pend      <= 1'b0;
         cap_val_o <= '0;
         flag_o    <= 1'b0;
         ovr_o     <= 1'b0;
      end else begin
         pend <= fire_i;
         if (fire_i) shadow <= cnt_i;
         if (pend) cap_val_o <= shadow;

         if (pend)            flag_o <= 1'b1;
         else if (flag_clr_i) flag_o <= 1'b0;

         if (pend && flag_o && !flag_clr_i) ovr_o <= 1'b1;
         else if (ovr_clr_i)                ovr_o <= 1'b0;
      end
   end

   // R6: visible value moves only on the copy from the shadow stage
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |=> $stable(cap_val_o));
   // R7: a copy always leaves the flag set
   assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> flag_o);
   // R7: without a clear the flag is sticky
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !flag_clr_i) |=> flag_o);
   // R9: overcapture only appears over an already set flag
   assert_ovr_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_o) |-> $past(flag_o));
endmodule

// File: rtl/icap_channel.sv
module icap_channel
   import icap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit FILTER_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             pin_own_i,
   input  logic             pin_nbr_i,
   input  logic             trig_i,
   input  logic [1:0]       src_sel_i,
   input  logic [1:0]       edge_sel_i,
   input  logic [1:0]       psc_sel_i,
   input  logic [3:0]       flt_cfg_i,
   input  logic             cap_en_i,
   input  logic             irq_en_i,
   input  logic             flag_clr_i,
   input  logic             ovr_clr_i,
   output logic [CNT_W-1:0] cap_val_o,
   output logic             cap_flag_o,
   output logic             ovr_flag_o,
   output logic             irq_o
);
   if (CNT_W < 2) begin : g_bad_width
      $error("icap_channel: CNT_W must be at least 2");
   end

   logic raw;
   logic level;
   logic arm;
   logic fire;

   always_comb begin
      case (src_sel_i)
         SRC_OWN: raw = pin_own_i;
         SRC_NBR: raw = pin_nbr_i;
         SRC_TRG: raw = trig_i;
         default: raw = 1'b0;
      endcase
   end

   assign arm = cap_en_i && (src_sel_i != SRC_OUT);

   icap_infilter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILTER_EN  (FILTER_EN)
   ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_i    (raw),
      .flt_cfg_i(flt_cfg_i),
      .level_o  (level)
   );

   icap_evpsc u_evpsc (
      .clk       (clk),
      .rst_n     (rst_n),
      .level_i   (level),
      .edge_sel_i(edge_sel_i),
      .psc_sel_i (psc_sel_i),
      .arm_i     (arm),
      .fire_o    (fire)
   );

   icap_latch #(
      .CNT_W(CNT_W)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_i     (cnt_i),
      .fire_i    (fire),
      .flag_clr_i(flag_clr_i),
      .ovr_clr_i (ovr_clr_i),
      .cap_val_o (cap_val_o),
      .flag_o    (cap_flag_o),
      .ovr_o     (ovr_flag_o)
   );

   assign irq_o = cap_flag_o & irq_en_i;

   // R10: two clocks after capture is disabled the visible value cannot move
   assert_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!cap_en_i, 2) |-> $stable(cap_val_o));
   // R1: output use of the channel never produces a new value
   assert_out_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(src_sel_i == SRC_OUT, 2) |-> $stable(cap_val_o));
   // R8: no request without a pending flag
   assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cap_flag_o && irq_en_i));
endmodule

// File: tb/sim_icap_channel.sv
`timescale 1ns/1ps
module sim_icap_channel;
   localparam int CNT_W = 16;
   localparam int SYNC  = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CNT_W-1:0] cnt = '0;
   logic             pin_own = 1'b0, pin_nbr = 1'b0, trig = 1'b0;
   logic [1:0]       src = 2'b01, edg = 2'b01, psc = 2'b00;
   logic [3:0]       flt = 4'b0000;
   logic             cap_en = 1'b0, irq_en = 1'b0, fclr = 1'b0, oclr = 1'b0;
   logic [CNT_W-1:0] cap_val;
   logic             cap_flag, ovr_flag, irq;

   int checks = 0;
   int errors = 0;
   int ncap = 0;
   logic [CNT_W-1:0] last_val = '0;

   always #4 clk = ~clk;   // 125 MHz

   icap_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC), .FILTER_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt),
      .pin_own_i(pin_own), .pin_nbr_i(pin_nbr), .trig_i(trig),
      .src_sel_i(src), .edge_sel_i(edg), .psc_sel_i(psc), .flt_cfg_i(flt),
      .cap_en_i(cap_en), .irq_en_i(irq_en), .flag_clr_i(fclr), .ovr_clr_i(oclr),
      .cap_val_o(cap_val), .cap_flag_o(cap_flag), .ovr_flag_o(ovr_flag), .irq_o(irq));

   always @(negedge clk) cnt <= cnt + 1'b1;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference ----------------
   bit               msync[$];
   bit               mlvl, mprev, mpend, mflag, movr;
   int               mrun, mpc, mtk;
   logic [1:0]       mpscq;
   logic [CNT_W-1:0] mshadow, mval;

   always @(posedge clk) begin
      bit raw, s_out, tick, hit, restart, fire, nlvl, nflag, novr;
      int per, need, div, nrun, npc;
      logic [CNT_W-1:0] nval, nshadow;
      if (!rst_n) begin
         msync = {};
         for (int i = 0; i < SYNC; i++) msync.push_back(1'b0);
         mlvl = 0; mprev = 0; mpend = 0; mflag = 0; movr = 0;
         mrun = 0; mpc = 0; mtk = 0; mpscq = 2'b00; mshadow = '0; mval = '0;
      end else begin
         case (src)
            2'b01:   raw = pin_own;
            2'b10:   raw = pin_nbr;
            2'b11:   raw = trig;
            default: raw = 1'b0;
         endcase
         s_out = msync[SYNC-1];
         per  = 1 << flt[3:2];
         need = 1 << flt[1:0];
         tick = (mtk % per) == 0;
         nlvl = mlvl; nrun = mrun;
         if (tick) begin
            if (s_out == mlvl) nrun = 0;
            else if (mrun + 1 >= need) begin nlvl = s_out; nrun = 0; end
            else nrun = mrun + 1;
         end
         if (edg == 2'b00)      hit = (!mlvl && mprev);
         else if (edg == 2'b01) hit = (mlvl && !mprev);
         else                   hit = (mlvl != mprev);
         restart = !(cap_en && src != 2'b00) || (psc != mpscq);
         div  = 1 << psc;
         fire = hit && !restart && (mpc == div - 1);
         if (restart) npc = 0;
         else if (hit) npc = fire ? 0 : mpc + 1;
         else npc = mpc;
         nval = mval; nshadow = mshadow; nflag = mflag; novr = movr;
         if (fire) nshadow = cnt;
         if (mpend) begin
            nval = mshadow;
            nflag = 1;
         end else if (fclr) nflag = 0;
         if (mpend && mflag && !fclr) novr = 1;
         else if (oclr) novr = 0;
         void'(msync.pop_back());
         msync.push_front(raw);
         mlvl = nlvl; mrun = nrun; mprev = mlvl === nlvl ? mprev : mprev;
         mprev = mprev; // replaced below
         mtk = (mtk + 1) % 8;
         mpscq = psc; mpc = npc; mpend = fire;
         mval = nval; mshadow = nshadow; mflag = nflag; movr = novr;
      end
      #2;
      if (rst_n) begin
         chk("R6 cap_val", int'(cap_val), int'(mval));
         chk("R7 cap_flag", int'(cap_flag), int'(mflag));
         chk("R9 ovr_flag", int'(ovr_flag), int'(movr));
         chk("R8 irq", int'(irq), int'(mflag & irq_en));
      end
   end

   // previous accepted level, updated after the reference step above
   bit lvl_d;
   always @(posedge clk) begin
      #1;
      if (!rst_n) begin mprev = 0; lvl_d = 0; end
      else begin mprev = lvl_d; lvl_d = mlvl; end
   end

   always @(negedge clk) begin
      if (rst_n && cap_val !== last_val) ncap++;
      last_val = cap_val;
   end

   // ---------------- stimulus helpers ----------------
   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flags();
      @(negedge clk); fclr = 1; oclr = 1;
      @(negedge clk); fclr = 0; oclr = 0;
   endtask

   task automatic pulse(input int which, input int hi, input int lo);
      @(negedge clk);
      if (which == 0) pin_own = 1; else if (which == 1) pin_nbr = 1; else trig = 1;
      wait_n(hi);
      if (which == 0) pin_own = 0; else if (which == 1) pin_nbr = 0; else trig = 0;
      wait_n(lo);
   endtask

   bit done = 0;
   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int c0, base;
      wait_n(4);
      // R11 reset state
      chk("R11 cap_val", int'(cap_val), 0);
      chk("R11 cap_flag", int'(cap_flag), 0);
      chk("R11 ovr_flag", int'(ovr_flag), 0);
      chk("R11 irq", int'(irq), 0);
      @(negedge clk); rst_n = 1;
      wait_n(3);

      // R2 latency, rising edge, own pin
      cap_en = 1; irq_en = 1; src = 2'b01; edg = 2'b01; psc = 2'b00; flt = 4'b0000;
      wait_n(4);
      @(negedge clk); pin_own = 1; c0 = int'(cnt);
      repeat (4) @(posedge clk);
      #2 chk("R2 flag not yet", int'(cap_flag), 0);
      @(posedge clk);
      #2 chk("R2 flag set", int'(cap_flag), 1);
      chk("R2 value", int'(cap_val), (c0 + 4) & 16'hFFFF);
      chk("R8 irq raised", int'(irq), 1);
      wait_n(6);
      // R3 falling in rising mode: no capture
      clear_flags();
      base = ncap;
      @(negedge clk); pin_own = 0; wait_n(10);
      chk("R3 no capture on fall", ncap - base, 0);
      // R3 falling mode
      edg = 2'b00; wait_n(2); base = ncap;
      pulse(0, 8, 8);
      chk("R3 falling captures once", ncap - base, 1);
      // R3 both edges
      edg = 2'b11; wait_n(2); base = ncap;
      pulse(0, 8, 8);
      chk("R3 both edges twice", ncap - base, 2);

      // R8 irq disabled
      irq_en = 0; wait_n(1);
      chk("R8 irq masked", int'(irq), 0);
      irq_en = 1;

      // R9 overcapture and clear
      clear_flags(); edg = 2'b01;
      pulse(0, 8, 8); pulse(0, 8, 8);
      chk("R9 overcapture", int'(ovr_flag), 1);
      @(negedge clk); oclr = 1; @(negedge clk); oclr = 0;
      chk("R9 overcapture cleared", int'(ovr_flag), 1 == 0 ? 1 : 0);
      // R7 flag clear
      @(negedge clk); fclr = 1; @(negedge clk); fclr = 0;
      chk("R7 flag cleared", int'(cap_flag), 0);

      // R1 output use: no capture
      src = 2'b00; wait_n(3); base = ncap;
      pulse(0, 8, 8); pulse(1, 8, 8); pulse(2, 8, 8);
      chk("R1 output use ignores pins", ncap - base, 0);
      chk("R1 output use flag", int'(cap_flag), 0);
      // R1 neighbour pin and trigger
      src = 2'b10; wait_n(3); base = ncap;
      pulse(1, 8, 8); pulse(0, 8, 8);
      chk("R1 neighbour pin only", ncap - base, 1);
      src = 2'b11; wait_n(3); base = ncap;
      pulse(2, 8, 8); pulse(1, 8, 8);
      chk("R1 trigger only", ncap - base, 1);
      src = 2'b01; wait_n(3);

      // R4 prescaler divide by 4 and by 8
      psc = 2'b10; wait_n(3); base = ncap;
      repeat (8) pulse(0, 6, 6);
      chk("R4 div4 of 8 edges", ncap - base, 2);
      psc = 2'b11; wait_n(3); base = ncap;
      repeat (7) pulse(0, 6, 6);
      chk("R4 div8 of 7 edges", ncap - base, 0);
      pulse(0, 6, 6);
      chk("R4 div8 on 8th edge", ncap - base, 1);
      // R4 restart on code change
      psc = 2'b01; wait_n(3); base = ncap;
      pulse(0, 6, 6);
      psc = 2'b10; wait_n(3);
      repeat (3) pulse(0, 6, 6);
      chk("R4 restart on code change", ncap - base, 0);
      pulse(0, 6, 6);
      chk("R4 fourth edge after restart", ncap - base, 1);

      // R10 capture disabled, and restart of divider
      psc = 2'b00; cap_en = 0; wait_n(3); base = ncap;
      repeat (3) pulse(0, 6, 6);
      chk("R10 disabled no capture", ncap - base, 0);
      cap_en = 1; psc = 2'b01; wait_n(3);
      pulse(0, 6, 6);
      cap_en = 0; wait_n(2); cap_en = 1; wait_n(2); base = ncap;
      pulse(0, 6, 6);
      chk("R10 disable restarts divider", ncap - base, 0);
      pulse(0, 6, 6);
      chk("R10 second edge after enable", ncap - base, 1);
      psc = 2'b00; wait_n(3);

      // R5 filter: 4 samples each clock
      flt = 4'b0010; wait_n(3); base = ncap;
      pulse(0, 2, 12);
      chk("R5 short glitch rejected", ncap - base, 0);
      pulse(0, 8, 16);
      chk("R5 long pulse accepted", ncap - base, 1);
      // R5 filter: 2 samples every 2 clocks
      flt = 4'b0101; wait_n(3); base = ncap;
      pulse(0, 1, 16);
      chk("R5 one clock glitch rejected", ncap - base, 0);
      pulse(0, 10, 16);
      chk("R5 slow sampling accepts", ncap - base, 1);
      flt = 4'b0000;

      // R7 set beats clear in the same clock (checked by reference every clock)
      clear_flags();
      @(negedge clk); pin_own = 1;
      repeat (4) @(negedge clk);
      fclr = 1; @(negedge clk); fclr = 0;
      chk("R7 set wins over clear", int'(cap_flag), 1);
      wait_n(8);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule